// File: doc/BRIEF.md
# Oversampling Serial Byte Receiver

This block turns an asynchronous serial line into a stream of bytes. A 16x sampling enable, made elsewhere, paces it. The line first passes through a two-flop synchronizer. A high-to-low transition seen while the receiver is idle does not yet start a character: it only arms a tick counter. On the eighth tick after that transition the line is checked again. If the line is still low, the start is accepted and the data bits, an optional parity bit and the stop bit are each sampled sixteen ticks apart, least significant bit first. If the line has already returned high, the transition was noise: the receiver drops it without a trace and waits for the next edge.

Each finished character goes into a 16-entry queue together with its own parity, framing and break flags. When `fifo_en` is low, the queue holds only one byte and acts as a single holding register. Bytes leave on a valid/ready stream. `out_valid` stays high and `out_data` stays stable until a cycle in which `out_ready` is also high, and that cycle removes the byte. The serial line cannot be stalled. When the queue is full, an arriving character is discarded and the overrun flag records it, so any back-pressure held longer than the remaining space costs data. A five-bit status vector reports data-ready, overrun and the error flags of the byte currently at the head of the queue.

Top module: `rx_line_receiver`

## Requirements
- R1: After reset, `out_valid` is 0 and every bit of `line_status` is 0.
- R2: After a falling edge on the synchronized line, the line is sampled on the 8th tick. A low level accepts the start. A high level abandons the character: a low pulse of 8 ticks produces no byte, and one of 9 ticks is accepted.
- R3: Data bits are sampled every 16 ticks after the start check, first received bit into bit 0 of `out_data`. Every byte value 0 to 255 is delivered unchanged.
- R4: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` and `line_status[4:2]` stay unchanged.
- R5: `line_status[0]` is 1 exactly while a byte is available and drops to 0 in the cycle after the last byte is taken. Bits 4 to 2 read 0 when no byte is available.
- R6: Bytes leave in arrival order, and the queue holds 16 of them when `fifo_en` is 1. A character that completes while the queue is full is discarded and sets `line_status[1]` (overrun). The next handshake on the output clears it.
- R7: With `parity_en` high, one parity bit follows the data. `parity_odd`=0 expects an even count of ones over data plus parity, and 1 expects an odd count. A mismatch sets `line_status[2]` for that byte.
- R8: A stop bit sampled as 0 sets `line_status[3]` (framing error) for that byte, and the byte is still delivered.
- R9: A character whose data, parity and stop samples are all 0 sets `line_status[4]` (break) as well as bit 3. No further character starts until the line has been high for at least one tick.
- R10: With `fifo_en` at 0, capacity is one byte. A second character that arrives before the first is read is discarded and sets overrun.
- R11: The receiver advances only on cycles where `tick16` is 1. With ticks every third clock, bytes are received correctly at the correspondingly slower bit rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Sampling enable at 16x the bit rate |
| rxd | input | 1 | Asynchronous serial input, idle high |
| fifo_en | input | 1 | 1: 16-byte queue, 0: single holding register |
| parity_en | input | 1 | Expect a parity bit after the data |
| parity_odd | input | 1 | 1: odd parity, 0: even parity |
| out_valid | output | 1 | Byte available at the output |
| out_ready | input | 1 | Consumer accepts the byte this cycle |
| out_data | output | DATA_BITS | Head byte of the queue |
| line_status | output | 5 | {break, framing, parity, overrun, data ready} |

## Verification
The assertions assume that `fifo_en` changes only while the queue is empty, so the one-byte bound in holding mode is never broken by a mode switch with bytes already stored. They also assume that `out_ready` is driven from registered logic and never reacts to `out_valid` in the same cycle. The bench sets the mode and parity controls only between characters and with the queue drained. It drives `rxd` and `out_ready` on the falling clock edge, so every input is stable at each rising edge the design sees.

// File: rtl/rx_pkg.sv
package rx_pkg;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PARITY,
    RX_STOP
  } rx_state_e;

  typedef struct packed {
    logic brk;
    logic frm;
    logic par;
  } rx_flags_t;

  localparam int FLAG_W = 3;

endpackage

// File: rtl/rx_sync_edge.sv
module rx_sync_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic rxd_raw,
  output logic line,
  output logic fall
);

  logic [SYNC_STAGES-1:0] chain;
  logic                   prev_tick_level;

  // synchronizer chain, idle-high reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[SYNC_STAGES-2:0], rxd_raw};
  end

  assign line = chain[SYNC_STAGES-1];

  // level seen at the previous sampling tick
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    prev_tick_level <= 1'b1;
    else if (tick) prev_tick_level <= line;
  end

  assign fall = tick && prev_tick_level && !line;

endmodule

// File: rtl/rx_framer.sv
module rx_framer
  import rx_pkg::*;
#(
  parameter int DATA_BITS  = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 line,
  input  logic                 fall,
  input  logic                 parity_en,
  input  logic                 parity_odd,
  output logic                 push,
  output logic [DATA_BITS-1:0] push_data,
  output rx_flags_t            push_flags
);

  localparam int CW   = $clog2(OVERSAMPLE);
  localparam int BW   = $clog2(DATA_BITS + 1);
  localparam int MID  = OVERSAMPLE / 2 - 1;
  localparam int LAST = OVERSAMPLE - 1;

  rx_state_e            state;
  logic [CW-1:0]        cnt;
  logic [BW-1:0]        bitn;
  logic [DATA_BITS-1:0] shreg;
  logic                 pbit;
  logic                 all_zero;
  logic                 at_mid;
  logic                 at_last;

  assign at_mid  = (cnt == CW'(MID));
  assign at_last = (cnt == CW'(LAST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= RX_IDLE;
      cnt        <= '0;
      bitn       <= '0;
      shreg      <= '0;
      pbit       <= 1'b0;
      all_zero   <= 1'b1;
      push       <= 1'b0;
      push_data  <= '0;
      push_flags <= '0;
    end else begin
      push <= 1'b0;
      if (tick) begin
        unique case (state)
          RX_IDLE: begin
            if (fall) begin
              cnt   <= '0;
              state <= RX_START;
            end
          end
          RX_START: begin
            if (at_mid) begin
              cnt <= '0;
              if (!line) begin
                state    <= RX_DATA;
                bitn     <= '0;
                all_zero <= 1'b1;
                pbit     <= 1'b0;
              end else begin
                state <= RX_IDLE;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_DATA: begin
            if (at_last) begin
              cnt      <= '0;
              shreg    <= {line, shreg[DATA_BITS-1:1]};
              all_zero <= all_zero & ~line;
              if (bitn == BW'(DATA_BITS - 1)) state <= parity_en ? RX_PARITY : RX_STOP;
              else                             bitn  <= bitn + 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_PARITY: begin
            if (at_last) begin
              cnt      <= '0;
              pbit     <= line;
              all_zero <= all_zero & ~line;
              state    <= RX_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_STOP: begin
            if (at_last) begin
              cnt            <= '0;
              push           <= 1'b1;
              push_data      <= shreg;
              push_flags.frm <= ~line;
              push_flags.brk <= all_zero & ~line;
              push_flags.par <= parity_en & ((^shreg ^ pbit) != parity_odd);
              state          <= RX_IDLE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/rx_fifo.sv
module rx_fifo #(
  parameter int WIDTH = 11,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       limit_one,
  input  logic                       push,
  input  logic [WIDTH-1:0]           push_word,
  input  logic                       pop,
  output logic [WIDTH-1:0]           head_word,
  output logic                       nonempty,
  output logic                       full,
  output logic [$clog2(DEPTH):0]     level
);

  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr;
  logic [AW-1:0]    rd_ptr;
  logic             accept;
  logic             take;

  assign nonempty  = (level != '0);
  assign full      = limit_one ? nonempty : (level == LW'(DEPTH));
  assign accept    = push && !full;
  assign take      = pop && nonempty;
  assign head_word = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (accept) mem[wr_ptr] <= push_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (accept) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (take)   rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      unique case ({accept, take})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

endmodule

// File: rtl/rx_line_receiver.sv
module rx_line_receiver
  import rx_pkg::*;
#(
  parameter int DATA_BITS   = 8,
  parameter int OVERSAMPLE  = 16,
  parameter int FIFO_DEPTH  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick16,
  input  logic                 rxd,
  input  logic                 fifo_en,
  input  logic                 parity_en,
  input  logic                 parity_odd,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [DATA_BITS-1:0] out_data,
  output logic [4:0]           line_status
);

  localparam int WORD_W = DATA_BITS + FLAG_W;
  localparam int LVL_W  = $clog2(FIFO_DEPTH) + 1;

  logic                 line_s;
  logic                 line_fall;
  logic                 frame_push;
  logic [DATA_BITS-1:0] frame_data;
  rx_flags_t            frame_flags;
  logic [WORD_W-1:0]    head_word;
  logic                 fifo_full;
  logic [LVL_W-1:0]     fifo_level;
  rx_flags_t            head_flags;
  logic                 overrun;
  logic                 handshake;

  rx_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick16),
    .rxd_raw (rxd),
    .line    (line_s),
    .fall    (line_fall)
  );

  rx_framer #(.DATA_BITS(DATA_BITS), .OVERSAMPLE(OVERSAMPLE)) u_framer (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick16),
    .line       (line_s),
    .fall       (line_fall),
    .parity_en  (parity_en),
    .parity_odd (parity_odd),
    .push       (frame_push),
    .push_data  (frame_data),
    .push_flags (frame_flags)
  );

  rx_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .limit_one (~fifo_en),
    .push      (frame_push),
    .push_word ({frame_flags, frame_data}),
    .pop       (out_ready),
    .head_word (head_word),
    .nonempty  (out_valid),
    .full      (fifo_full),
    .level     (fifo_level)
  );

  assign out_data   = head_word[DATA_BITS-1:0];
  assign head_flags = rx_flags_t'(head_word[WORD_W-1:DATA_BITS]);
  assign handshake  = out_valid && out_ready;

  // overrun: set by a dropped character, cleared by the next read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       overrun <= 1'b0;
    else if (frame_push && fifo_full) overrun <= 1'b1;
    else if (handshake)               overrun <= 1'b0;
  end

  assign line_status = {out_valid & head_flags.brk,
                        out_valid & head_flags.frm,
                        out_valid & head_flags.par,
                        overrun,
                        out_valid};

endmodule

// File: rtl/rx_line_receiver_chk.sv
module rx_line_receiver_chk #(
  parameter int DATA_BITS  = 8,
  parameter int FIFO_DEPTH = 16
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          out_valid,
  input logic                          out_ready,
  input logic [DATA_BITS-1:0]          out_data,
  input logic [4:0]                    line_status,
  input logic                          fifo_en,
  input logic [$clog2(FIFO_DEPTH):0]   level,
  input logic                          push,
  input logic                          full
);

  // R4
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(line_status[4:2])));

  // R6
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= ($clog2(FIFO_DEPTH) + 1)'(FIFO_DEPTH));

  // R6
  overrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_status[1]) |-> $past(push && full));

  // R5
  ready_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && level == 1 && !push) |=> !line_status[0]);

  // R5
  flags_need_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !line_status[0] |-> (line_status[4:2] == 3'b000));

  // R9
  break_implies_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_status[4] |-> line_status[3]);

  // R10
  holding_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |-> (level <= 1));

endmodule

bind rx_line_receiver rx_line_receiver_chk #(
  .DATA_BITS  (DATA_BITS),
  .FIFO_DEPTH (FIFO_DEPTH)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_data    (out_data),
  .line_status (line_status),
  .fifo_en     (fifo_en),
  .level       (fifo_level),
  .push        (frame_push),
  .full        (fifo_full)
);

// File: tb/tb_rx_line_receiver.sv
module tb_rx_line_receiver;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxd = 1'b1;
  logic       fifo_en = 1'b1;
  logic       parity_en = 1'b0;
  logic       parity_odd = 1'b0;
  logic       out_ready = 1'b0;
  logic       out_valid;
  logic [7:0] out_data;
  logic [4:0] line_status;
  logic       tick16;

  int tdiv = 1;
  int tcnt = 0;
  int nchecks = 0;
  int nfail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  always @(posedge clk) tcnt <= (tcnt + 1 >= tdiv) ? 0 : tcnt + 1;
  assign tick16 = (tcnt == 0);

  rx_line_receiver dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick16      (tick16),
    .rxd         (rxd),
    .fifo_en     (fifo_en),
    .parity_en   (parity_en),
    .parity_odd  (parity_odd),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_data    (out_data),
    .line_status (line_status)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchecks++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hold(input int ticks);
    repeat (ticks * tdiv) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input bit with_par, input logic pbit, input logic stop);
    @(negedge clk);
    rxd = 1'b0;
    hold(16);
    for (int i = 0; i < 8; i++) begin
      rxd = d[i];
      hold(16);
    end
    if (with_par) begin
      rxd = pbit;
      hold(16);
    end
    rxd = stop;
    hold(16);
    repeat (4) @(negedge clk);
  endtask

  task automatic pop_check(input logic [7:0] exp_d, input logic [2:0] exp_f, input string tag);
    @(negedge clk);
    chk(out_valid == 1'b1, {tag, " valid"}, out_valid, 1);
    chk(out_data == exp_d, {tag, " data"}, out_data, exp_d);
    chk(line_status[4:2] == exp_f, {tag, " flags"}, line_status[4:2], exp_f);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nchecks - nfail, nchecks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchecks++;
    nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(out_valid == 1'b0, "R1 valid", out_valid, 0);
    chk(line_status == 5'd0, "R1 status", line_status, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(line_status == 5'd0, "R1 status after release", line_status, 0);

    // R2 low pulse of 8 ticks is rejected
    rxd = 1'b0; hold(8); rxd = 1'b1; hold(200);
    chk(out_valid == 1'b0, "R2 short pulse", out_valid, 0);
    // R2 low pulse of 9 ticks is a start followed by all-ones data
    rxd = 1'b0; hold(9); rxd = 1'b1; hold(200);
    pop_check(8'hFF, 3'b000, "R2 long pulse");

    // R3 sweep of every byte value
    for (int v = 0; v < 256; v++) begin
      send_frame(8'(v), 0, 1'b0, 1'b1);
      pop_check(8'(v), 3'b000, "R3 sweep");
    end

    // R7 parity: both senses, correct and flipped parity bit
    parity_en = 1'b1;
    for (int odd = 0; odd < 2; odd++) begin
      parity_odd = odd[0];
      for (int v = 0; v < 64; v++) begin
        for (int flip = 0; flip < 2; flip++) begin
          logic [7:0] d;
          logic       p;
          d = 8'((v * 37 + odd * 11) % 256);
          p = (^d) ^ odd[0] ^ flip[0];
          send_frame(d, 1, p, 1'b1);
          pop_check(d, {2'b00, flip[0]}, "R7 parity");
        end
      end
    end
    parity_en  = 1'b0;
    parity_odd = 1'b0;

    // R11 slower tick rate
    tdiv = 3;
    send_frame(8'hA5, 0, 1'b0, 1'b1);
    pop_check(8'hA5, 3'b000, "R11 tick/3 first");
    send_frame(8'h3C, 0, 1'b0, 1'b1);
    pop_check(8'h3C, 3'b000, "R11 tick/3 second");
    tdiv = 1;
    hold(4);

    // R4 back-pressure, R5 data ready
    send_frame(8'h5A, 0, 1'b0, 1'b1);
    for (int k = 0; k < 10; k++) begin
      repeat (10) @(negedge clk);
      chk(out_valid == 1'b1 && out_data == 8'h5A, "R4 held under stall", out_data, 8'h5A);
    end
    chk(line_status[0] == 1'b1, "R5 ready while held", line_status[0], 1);
    pop_check(8'h5A, 3'b000, "R4 release");
    chk(line_status[0] == 1'b0, "R5 cleared after last read", line_status[0], 0);

    // R6 queue depth, order and overrun
    for (int i = 0; i < 17; i++) send_frame(8'(i * 13 + 7), 0, 1'b0, 1'b1);
    chk(line_status[1] == 1'b1, "R6 overrun set", line_status[1], 1);
    for (int i = 0; i < 16; i++) begin
      pop_check(8'(i * 13 + 7), 3'b000, "R6 order");
      if (i == 0) chk(line_status[1] == 1'b0, "R6 overrun cleared by read", line_status[1], 0);
    end
    chk(out_valid == 1'b0, "R6 17th dropped", out_valid, 0);

    // R8 framing error
    send_frame(8'h55, 0, 1'b0, 1'b0);
    rxd = 1'b1;
    hold(20);
    pop_check(8'h55, 3'b010, "R8 framing");
    chk(out_valid == 1'b0, "R8 single byte", out_valid, 0);

    // R9 break, then the line stays low
    send_frame(8'h00, 0, 1'b0, 1'b0);
    hold(48);
    rxd = 1'b1;
    hold(32);
    pop_check(8'h00, 3'b110, "R9 break");
    chk(out_valid == 1'b0, "R9 no restart while low", out_valid, 0);
    send_frame(8'h81, 0, 1'b0, 1'b1);
    pop_check(8'h81, 3'b000, "R9 recovery");

    // R10 holding register mode
    fifo_en = 1'b0;
    send_frame(8'h11, 0, 1'b0, 1'b1);
    send_frame(8'h22, 0, 1'b0, 1'b1);
    chk(line_status[1] == 1'b1, "R10 overrun", line_status[1], 1);
    pop_check(8'h11, 3'b000, "R10 first kept");
    chk(out_valid == 1'b0, "R10 second dropped", out_valid, 0);
    fifo_en = 1'b1;

    repeat (5) @(negedge clk);
    finish_run();
  end

endmodule